// File: doc/BRIEF.md
# Multiplexed Burst Bus Controller

This block runs transactions on a 32-bit bus that carries the address and the data on the same wires. A core-side port hands it one request at a time: a byte address, the direction, a code-fetch flag, a transfer count of one to four, the lane enables and the width of the target region (8, 16 or 32 bits). The controller then sequences one address cycle, the data cycles with any wait states the ready input asks for, and the recovery cycles that follow. It drives the strobes, lane enables, direction, data enable and last-transfer indicator along the way.

During the address cycle the transfer count is folded into the two low address bits. On narrow regions some lane-enable pins instead carry the low address bits, so that an 8-bit or 16-bit device can be addressed without extra pins. The partial word address steps through the burst as each transfer completes. Between transactions the controller can hand the bus to another master through a hold/acknowledge pair, and it refuses to do so while the core holds the bus locked for an atomic sequence.

Top module: `mbus_ctrl`

## Requirements
- R1: A request accepted in an idle cycle (req_valid and req_ready high at a rising edge) is followed by exactly one address cycle. In it, ads_n is low, ale is high, fetch shows the request's code flag, and ad_out carries req_addr[31:2] in bits 31:2 and the count minus one in bits 1:0 (00 = one transfer, 11 = four). ale and ads_n are inactive from the first data cycle on.
- R2: The wid output gives the region width captured at acceptance: 00 for 8 bits, 01 for 16 bits, 10 for 32 bits. It reads 10 after reset. While the controller is idle and core_halt is high, it reads 11.
- R3: On a 32-bit region, be_n is the inverse of req_be and stays constant from the address cycle through the last data cycle.
- R4: On a 16-bit region, be_n[3] is the inverse of req_be[1] (high byte), be_n[0] is the inverse of req_be[0] (low byte), be_n[1] carries the current address bit 1, and be_n[2] is 1.
- R5: On an 8-bit region, be_n[1:0] carry the current address bits 1:0 and be_n[3:2] are 11.
- R6: A data cycle in which rdy is low is repeated. It completes no transfer (rd_valid and wd_next stay low), and den_n stays low.
- R7: The current address bits 3:0 start at req_addr[3:0], with bits below the region width cleared. They advance by the region width in bytes (1, 2 or 4) after each completed transfer, wrapping within 16 bytes. The wa output shows bits 3:2.
- R8: blast_n is low in the final data cycle, including every wait state that stretches it, and high in the earlier data cycles.
- R9: den_n is low in every data cycle of a transaction and high in the address and recovery cycles. dtr is 1 for writes and 0 for reads, and it never changes while den_n is low.
- R10: After the final transfer the controller spends at least one recovery cycle, and it stays in recovery while rdy is low. The next address cycle comes no earlier than two cycles after the recovery cycle in which rdy is high.
- R11: When hold_req is high in an idle cycle and the bus is not locked, a pending request is not accepted. From the next cycle, hlda is 1 and drv_en and ad_oe are 0. hlda drops in the cycle after hold_req is seen low.
- R12: While idle, lock_n follows the inverse of lock_req one cycle later, and it does not change during data cycles. While lock_req or lock_n is active, hold is not granted.
- R13: In each data cycle whose rdy is high, a read asserts rd_valid with rd_data equal to ad_in, and a write asserts wd_next while ad_out carries wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request pending |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Byte address of the first transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = instruction fetch |
| req_cnt | input | 2 | Number of transfers minus one |
| req_be | input | 4 | Lane enables, active high |
| req_wid | input | 2 | Region width code |
| wr_data | input | 32 | Write data for the current transfer |
| wd_next | output | 1 | Current write transfer completes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| lock_req | input | 1 | Core asks for the bus to be locked |
| core_halt | input | 1 | Core is halted |
| ad_out | output | 32 | Address/data bus, driven value |
| ad_in | input | 32 | Address/data bus, sampled value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ale | output | 1 | Address latch enable, active high |
| ads_n | output | 1 | Address strobe, active low |
| be_n | output | 4 | Lane enables or low address bits, active low |
| wa | output | 2 | Address bits 3:2 within the burst |
| wid | output | 2 | Region width / halt code |
| dtr | output | 1 | Direction, 1 = transmit |
| den_n | output | 1 | Data enable, active low |
| blast_n | output | 1 | Last transfer, active low |
| fetch | output | 1 | Transaction is a code fetch |
| rdy | input | 1 | Ready from memory |
| hold_req | input | 1 | Another master requests the bus |
| hlda | output | 1 | Hold acknowledge |
| lock_n | output | 1 | Bus lock, active low |
| drv_en | output | 1 | Drive enable for strobes and controls |

## Verification
An accepted request shows its address cycle one clock after the accepting edge, and the first data cycle follows one clock later. Read data and write-strobe results are combinational in the very cycle rdy is high. lock_n and hlda respond one clock after the input that moves them. The bench drives inputs 1 ns after a rising edge and samples at the falling edge. A scoreboard records the expected address cycle and every expected transfer in order. The monitor pops one entry per address strobe or ready data cycle, so a transfer that arrives early, late or twice is caught. The wait, recovery, hold and lock cycles are checked inline at the falling edges the requirements name.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int LANES = 4;
  localparam int CNT_W = 2;
  localparam int PA_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_RECOV = 3'd3,
    ST_HOLD  = 3'd4
  } bus_st_e;

  localparam logic [1:0] WID_8    = 2'b00;
  localparam logic [1:0] WID_16   = 2'b01;
  localparam logic [1:0] WID_32   = 2'b10;
  localparam logic [1:0] WID_HALT = 2'b11;

  // bytes moved by one transfer on a region of width code w
  function automatic logic [PA_W-1:0] beat_step(input logic [1:0] w);
    logic [PA_W-1:0] s;
    case (w)
      WID_8:   s = 4'd1;
      WID_16:  s = 4'd2;
      default: s = 4'd4;
    endcase
    return s;
  endfunction

  // clear the offset bits that a region of this width cannot address
  function automatic logic [PA_W-1:0] align_start(input logic [PA_W-1:0] a,
                                                  input logic [1:0] w);
    return a & ~(beat_step(w) - 4'd1);
  endfunction

  // active-low lane pins; narrow regions reuse low pins as address bits
  function automatic logic [LANES-1:0] lane_map(input logic [1:0] w,
                                                input logic [LANES-1:0] be,
                                                input logic [PA_W-1:0] pa);
    logic [LANES-1:0] r;
    r = '1;
    case (w)
      WID_8: r[1:0] = pa[1:0];
      WID_16: begin
        r[0] = ~be[0];
        r[1] = pa[1];
        r[3] = ~be[1];
      end
      default: r = ~be;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold_req,
  input  logic    lock_busy,
  input  logic    rdy,
  input  logic    last_beat,
  output bus_st_e st,
  output logic    req_take,
  output logic    grant_hold,
  output logic    beat_done
);

  bus_st_e st_nx;

  always_comb begin
    grant_hold = (st == ST_IDLE) && hold_req && !lock_busy;
    req_take   = (st == ST_IDLE) && req_valid && !grant_hold;
    beat_done  = (st == ST_DATA) && rdy;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (grant_hold)    st_nx = ST_HOLD;
        else if (req_take) st_nx = ST_ADDR;
      end
      ST_ADDR:  st_nx = ST_DATA;
      ST_DATA:  if (beat_done && last_beat) st_nx = ST_RECOV;
      ST_RECOV: if (rdy) st_nx = ST_IDLE;
      ST_HOLD:  if (!hold_req) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R10
  rcv_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOV && !rdy) |=> (st == ST_RECOV));

  // R10
  last_to_rcv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && last_beat) |=> (st == ST_RECOV));

endmodule

// File: rtl/mbus_beat.sv
module mbus_beat
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [PA_W-1:0]  start_pa,
  input  logic [CNT_W-1:0] beats_m1,
  input  logic [1:0]       wid_ld,
  input  logic [1:0]       wid_run,
  output logic [PA_W-1:0]  pa,
  output logic             last_beat
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa     <= '0;
      remain <= '0;
    end else if (load) begin
      pa     <= align_start(start_pa, wid_ld);
      remain <= beats_m1;
    end else if (advance) begin
      pa <= pa + beat_step(wid_run);
      if (remain != '0) remain <= remain - 1'b1;
    end
  end

  assign last_beat = (remain == '0);

  // R7
  pa_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (pa != $past(pa)));

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           st,
  input  logic              write_q,
  input  logic [1:0]        wid_q,
  input  logic [LANES-1:0]  be_q,
  input  logic [PA_W-1:0]   pa,
  input  logic              last_beat,
  input  logic [DATA_W-1:2] addr_hi,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              core_halt,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              ads_n,
  output logic              den_n,
  output logic              blast_n,
  output logic [LANES-1:0]  be_n,
  output logic [1:0]        wa,
  output logic [1:0]        wid,
  output logic              hlda,
  output logic              drv_en
);

  logic in_addr, in_data;

  always_comb begin
    in_addr = (st == ST_ADDR);
    in_data = (st == ST_DATA);
    ale     = in_addr;
    ads_n   = !in_addr;
    den_n   = !in_data;
    blast_n = !(in_data && last_beat);
    hlda    = (st == ST_HOLD);
    drv_en  = (st != ST_HOLD);
    ad_oe   = in_addr || (in_data && write_q);
    be_n    = lane_map(wid_q, be_q, pa);
    wa      = pa[3:2];
    wid     = ((st == ST_IDLE) && core_halt) ? WID_HALT : wid_q;
    if (in_addr)                ad_out = {addr_hi, cnt_q};
    else if (in_data && write_q) ad_out = wr_data;
    else                        ad_out = '0;
  end

  // R1
  ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> (ads_n && !ale && !den_n));

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_code,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic [LANES-1:0]  req_be,
  input  logic [1:0]        req_wid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wd_next,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lock_req,
  input  logic              core_halt,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic              ale,
  output logic              ads_n,
  output logic [LANES-1:0]  be_n,
  output logic [1:0]        wa,
  output logic [1:0]        wid,
  output logic              dtr,
  output logic              den_n,
  output logic              blast_n,
  output logic              fetch,
  input  logic              rdy,
  input  logic              hold_req,
  output logic              hlda,
  output logic              lock_n,
  output logic              drv_en
);

  bus_st_e            st;
  logic               req_take, grant_hold, beat_done, last_beat;
  logic [PA_W-1:0]    pa;
  logic [DATA_W-1:2]  addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               write_q, code_q, lock_q;
  logic [1:0]         wid_q;
  logic [LANES-1:0]   be_q;
  logic               lock_busy;

  assign lock_busy = lock_q || lock_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      write_q <= 1'b0;
      code_q  <= 1'b0;
      wid_q   <= WID_32;
      be_q    <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (req_take) begin
        addr_q  <= req_addr[DATA_W-1:2];
        cnt_q   <= req_cnt;
        write_q <= req_write;
        code_q  <= req_code;
        wid_q   <= req_wid;
        be_q    <= req_be;
      end
      if (st == ST_IDLE) lock_q <= lock_req;
    end
  end

  mbus_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hold_req   (hold_req),
    .lock_busy  (lock_busy),
    .rdy        (rdy),
    .last_beat  (last_beat),
    .st         (st),
    .req_take   (req_take),
    .grant_hold (grant_hold),
    .beat_done  (beat_done)
  );

  mbus_beat u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_take),
    .advance   (beat_done),
    .start_pa  (req_addr[PA_W-1:0]),
    .beats_m1  (req_cnt),
    .wid_ld    (req_wid),
    .wid_run   (wid_q),
    .pa        (pa),
    .last_beat (last_beat)
  );

  mbus_pins #(.DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .write_q   (write_q),
    .wid_q     (wid_q),
    .be_q      (be_q),
    .pa        (pa),
    .last_beat (last_beat),
    .addr_hi   (addr_q),
    .cnt_q     (cnt_q),
    .wr_data   (wr_data),
    .core_halt (core_halt),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .ads_n     (ads_n),
    .den_n     (den_n),
    .blast_n   (blast_n),
    .be_n      (be_n),
    .wa        (wa),
    .wid       (wid),
    .hlda      (hlda),
    .drv_en    (drv_en)
  );

  assign req_ready = req_take;
  assign rd_valid  = beat_done && !write_q;
  assign wd_next   = beat_done && write_q;
  assign rd_data   = ad_in;
  assign dtr       = write_q;
  assign fetch     = code_q;
  assign lock_n    = !lock_q;

  // R9
  dtr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !$past(den_n)) |-> $stable(dtr));

  // R8
  blast_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && !rdy) |=> !blast_n);

  // R3
  be32_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !$past(den_n) && wid == WID_32) |-> $stable(be_n));

  // R11
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!drv_en && !ad_oe && ads_n));

  // R12
  hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> (lock_n && $past(lock_n)));

  // R12
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> $stable(lock_n));

endmodule

// File: tb/mbus_ctrl_test.sv
`timescale 1ns/1ps
module mbus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_code = 0;
  logic [31:0] req_addr = '0, wr_data = '0, ad_in = '0;
  logic [1:0]  req_cnt = '0, req_wid = 2'b10;
  logic [3:0]  req_be = '0;
  logic        lock_req = 0, core_halt = 0, rdy = 0, hold_req = 0;
  logic        req_ready, wd_next, rd_valid, ad_oe, ale, ads_n, dtr;
  logic        den_n, blast_n, fetch, hlda, lock_n, drv_en;
  logic [31:0] rd_data, ad_out;
  logic [3:0]  be_n;
  logic [1:0]  wa, wid;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  typedef struct packed {
    logic        is_addr;
    logic [31:0] ad;
    logic [3:0]  ben;
    logic [1:0]  wa;
    logic        blast_n;
    logic [1:0]  wid;
    logic        wr;
  } exp_t;

  exp_t expq[$];

  always #4 clk = ~clk;

  mbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_code(req_code),
    .req_cnt(req_cnt), .req_be(req_be), .req_wid(req_wid), .wr_data(wr_data),
    .wd_next(wd_next), .rd_valid(rd_valid), .rd_data(rd_data),
    .lock_req(lock_req), .core_halt(core_halt), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .ale(ale), .ads_n(ads_n), .be_n(be_n), .wa(wa), .wid(wid),
    .dtr(dtr), .den_n(den_n), .blast_n(blast_n), .fetch(fetch), .rdy(rdy),
    .hold_req(hold_req), .hlda(hlda), .lock_n(lock_n), .drv_en(drv_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_lanes(input logic [1:0] w, input logic [3:0] be,
                                             input logic [3:0] p);
    if (w == 2'b10) return ~be;
    if (w == 2'b01) return {~be[1], 1'b1, p[1], ~be[0]};
    return {2'b11, p[1:0]};
  endfunction

  task automatic mon_item(input bit is_addr);
    exp_t e;
    string lt;
    if (expq.size() == 0) begin
      chk("R1 unexpected bus event", 32'd1, 32'd0);
      return;
    end
    e = expq.pop_front();
    lt = (e.wid == 2'b10) ? "R3 lanes" : (e.wid == 2'b01) ? "R4 lanes" : "R5 lanes";
    chk("R1 item kind", is_addr, e.is_addr);
    chk(lt, be_n, e.ben);
    if (is_addr) begin
      chk("R1 address word", ad_out, e.ad);
      chk("R2 width code", wid, e.wid);
      chk("R9 direction", dtr, e.wr);
    end else begin
      chk("R13 data", e.wr ? ad_out : rd_data, e.ad);
      chk("R13 strobe", e.wr ? wd_next : rd_valid, 32'd1);
      chk("R7 word bits", wa, e.wa);
      chk("R8 last flag", blast_n, e.blast_n);
    end
  endtask

  // monitor: one scoreboard entry per address strobe or completed transfer
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!ads_n)            mon_item(1'b1);
        else if (!den_n && rdy) mon_item(1'b0);
      end
    end
  end

  task automatic run_txn(input logic [31:0] addr, input logic [1:0] cnt, input bit wr,
                         input bit code, input logic [1:0] w, input logic [3:0] be,
                         input int wbeat, input int nw, input int rcv_w);
    logic [3:0] p0, p, step;
    exp_t e;
    p0   = (w == 2'b00) ? addr[3:0] : (w == 2'b01) ? {addr[3:1], 1'b0} : {addr[3:2], 2'b00};
    step = (w == 2'b00) ? 4'd1 : (w == 2'b01) ? 4'd2 : 4'd4;
    e = '{is_addr: 1'b1, ad: {addr[31:2], cnt}, ben: model_lanes(w, be, p0),
          wa: p0[3:2], blast_n: 1'b1, wid: w, wr: wr};
    expq.push_back(e);
    for (int b = 0; b <= int'(cnt); b++) begin
      p = p0 + step * b[3:0];
      e = '{is_addr: 1'b0, ad: addr ^ (32'h5a00_0000 + b), ben: model_lanes(w, be, p),
            wa: p[3:2], blast_n: (b == int'(cnt)) ? 1'b0 : 1'b1, wid: w, wr: wr};
      expq.push_back(e);
    end

    @(posedge clk); #1;
    req_addr = addr; req_cnt = cnt; req_write = wr; req_code = code;
    req_wid = w; req_be = be; req_valid = 1;
    @(negedge clk);
    chk("R1 request accepted", req_ready, 32'd1);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R1 ale in address cycle", ale, 32'd1);
    chk("R1 fetch flag", fetch, code);
    chk("R9 den off in address cycle", den_n, 32'd1);

    for (int b = 0; b <= int'(cnt); b++) begin
      wr_data = addr ^ (32'h5a00_0000 + b);
      ad_in   = addr ^ (32'h5a00_0000 + b);
      for (int k = 0; k < ((b == wbeat) ? nw : 0); k++) begin
        @(posedge clk); #1; rdy = 0;
        @(negedge clk);
        chk("R6 no transfer in wait", {rd_valid, wd_next}, 32'd0);
        chk("R6 den held in wait", den_n, 32'd0);
        chk("R8 last flag in wait", blast_n, (b == int'(cnt)) ? 32'd0 : 32'd1);
      end
      @(posedge clk); #1; rdy = 1;
      @(negedge clk);
      chk("R1 ale off in data", ale, 32'd0);
      chk("R9 den on in data", den_n, 32'd0);
    end

    for (int k = 0; k < rcv_w; k++) begin
      @(posedge clk); #1; rdy = 0;
      @(negedge clk);
      chk("R10 recovery holds", {ads_n, den_n}, 32'd3);
    end
    @(posedge clk); #1; rdy = 1;
    @(negedge clk);
    chk("R10 recovery exit cycle", {ads_n, den_n}, 32'd3);
    @(posedge clk); #1; rdy = 0;
    @(negedge clk);
    chk("R10 idle before next address", ads_n, 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 strobe idle after reset", {ads_n, ale}, 32'd2);
    chk("R8 last idle after reset", blast_n, 32'd1);
    chk("R9 den idle after reset", den_n, 32'd1);
    chk("R11 no hold after reset", {hlda, drv_en}, 32'd1);
    chk("R12 unlocked after reset", lock_n, 32'd1);
    chk("R2 width after reset", wid, 32'd2);

    // 32-bit four-transfer read with wrap of the word bits
    run_txn(32'h1000_0008, 2'd3, 0, 0, 2'b10, 4'hF, 0, 0, 0);
    // 32-bit write, waits on the first transfer, long recovery
    run_txn(32'h2000_0044, 2'd1, 1, 0, 2'b10, 4'b0011, 0, 2, 2);
    // 16-bit read with address bit 1 on a lane pin, code fetch
    run_txn(32'h3000_0006, 2'd3, 0, 1, 2'b01, 4'b0001, 2, 1, 0);
    // 8-bit write, waits on the last transfer
    run_txn(32'h4000_000D, 2'd2, 1, 0, 2'b00, 4'b0000, 2, 3, 1);
    // single transfer with a wait state
    run_txn(32'h5000_0010, 2'd0, 0, 0, 2'b10, 4'b1000, 0, 1, 0);

    // halt code while idle
    @(posedge clk); #1; core_halt = 1;
    @(negedge clk);
    chk("R2 halt code", wid, 32'd3);
    @(posedge clk); #1; core_halt = 0;
    @(negedge clk);
    chk("R2 width back after halt", wid, 32'd2);

    // hold with a competing request
    @(posedge clk); #1;
    req_addr = 32'h6000_0000; req_cnt = 0; req_write = 0; req_wid = 2'b10;
    req_valid = 1; hold_req = 1;
    @(negedge clk);
    chk("R11 request held off", req_ready, 32'd0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 hold granted", {hlda, drv_en, ad_oe}, 32'd4);
    chk("R11 no address in hold", ads_n, 32'd1);
    @(posedge clk); #1; hold_req = 0; req_valid = 0;
    @(negedge clk);
    chk("R11 hold kept until sampled", hlda, 32'd1);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 hold released", {hlda, drv_en}, 32'd1);

    // lock blocks hold
    @(posedge clk); #1; lock_req = 1;
    @(negedge clk);
    chk("R12 lock one cycle later", lock_n, 32'd1);
    @(posedge clk); #1; hold_req = 1;
    @(negedge clk);
    chk("R12 lock active", lock_n, 32'd0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R12 no hold while locked", hlda, 32'd0);
    run_txn(32'h7000_0020, 2'd1, 1, 0, 2'b10, 4'hF, 0, 0, 0);
    chk("R12 lock kept over transaction", lock_n, 32'd0);
    chk("R12 no hold after locked transaction", hlda, 32'd0);
    @(posedge clk); #1; lock_req = 0;
    @(negedge clk);
    chk("R12 still locked", {lock_n, hlda}, 32'd0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R12 unlocked, hold not yet", {lock_n, hlda}, 32'd2);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R12 hold after unlock", hlda, 32'd1);
    @(posedge clk); #1; hold_req = 0;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 back to idle", hlda, 32'd0);

    chk("R1 scoreboard drained", expq.size(), 32'd0);
    ended = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule